// File: doc/BRIEF.md
# Repeated-Input Pulse Detector

This block is a small clocked controller that watches two single-bit data lines, `hit_a` and `hit_b`, during strobe pulses carried on `pulse`. During each pulse at most one line should be high. The block remembers which line was high in the most recent pulse that had a high line. It raises `match` when a new pulse repeats that line, and it drops `match` when a new pulse uses the other line. Pulses with neither line high change nothing. So `match` reports whether the two latest active pulses came from the same source.

The state is split into two parts: `match` itself and the identity of the last active line. It is held in two J-K style state bits that behave like a master-slave pair. A master stage tracks the would-be next state while `pulse` is high. The slave state bits take that value only on the cycle where `pulse` falls. `match` already shows the new level from the first cycle of a pulse and keeps it after the pulse ends. Both lines high during a pulse is treated as illegal: the state is held and `clash` is raised. `pulse` is a level sampled on the system clock `clk`. The lines must be stable while it is high.

Top module: `pulse_repeat_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a `clk` edge) gives `match`=0 and `clash`=0. It also makes `hit_a` the remembered last line, so the first `hit_a` pulse after reset drives `match` to 1.
- R2: In a pulse where only the remembered line is high, `match` is 1.
- R3: In a pulse where only the non-remembered line is high, `match` is 0, and that line becomes the remembered one from then on.
- R4: A pulse with both lines low leaves `match` and the remembered line unchanged. A later pulse on the remembered line still gives `match`=1.
- R5: `match` responds combinationally in every cycle where `pulse` is high, starting with the first such cycle.
- R6: The state commits only when `pulse` falls. While `pulse` stays low, `match` holds the value shown during the last pulse.
- R7: While `pulse` is low, `hit_a` and `hit_b` have no effect on `match` or on the remembered line.
- R8: In a pulse with both lines high, `clash` is 1 for every cycle of that pulse, `match` keeps its prior value, and the remembered line is unchanged.
- R9: `clash` is 0 whenever `pulse` is low or at most one line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse | input | 1 | Strobe pulse level; lines are sampled while high |
| hit_a | input | 1 | First data line |
| hit_b | input | 1 | Second data line |
| match | output | 1 | High while the last two active pulses used the same line |
| clash | output | 1 | High during a pulse with both lines high |

## Verification
Two functions can meet in one cycle. One is the commit of the slave state at the falling edge of `pulse`. The other is `match` presenting the next pulse's result, which happens when a new pulse starts right after a one-cycle gap, or when the lines change in the very cycle `pulse` drops. The bench provokes both with back-to-back pulses of one cycle and with line changes during the gaps. On every clock it compares `match` and `clash` with a behavioural model that updates its memory only at the fall of `pulse`. A design that committed early, late, or off a stale master value would then show the wrong level in the gap cycle or in the next pulse.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    // Two state bits: which line carried the last 1, and the output level.
    typedef struct packed {
        logic last_b;   // 0: hit_a was last, 1: hit_b was last
        logic lvl;      // match level
    } rpd_state_t;

    localparam int STATE_W = $bits(rpd_state_t);

    localparam rpd_state_t ST_A = '{last_b: 1'b0, lvl: 1'b0};
    localparam rpd_state_t ST_B = '{last_b: 1'b0, lvl: 1'b1};
    localparam rpd_state_t ST_C = '{last_b: 1'b1, lvl: 1'b0};
    localparam rpd_state_t ST_D = '{last_b: 1'b1, lvl: 1'b1};

endpackage

// File: rtl/rpd_next.sv
module rpd_next
    import rpd_pkg::*;
(
    input  rpd_state_t cur,
    input  logic       hit_a,
    input  logic       hit_b,
    output rpd_state_t nxt,
    output logic       illegal
);
    always_comb begin
        nxt     = cur;
        illegal = hit_a & hit_b;
        if (hit_a && !hit_b) begin
            nxt.last_b = 1'b0;
            nxt.lvl    = ~cur.last_b;
        end else if (hit_b && !hit_a) begin
            nxt.last_b = 1'b1;
            nxt.lvl    = cur.last_b;
        end
    end
endmodule

// File: rtl/rpd_jk_bit.sv
module rpd_jk_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);
    logic q_d;
    logic q_q;

    always_comb begin
        q_d = (j & ~q_q) | (~k & q_q);
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= RST_VAL;
        else     q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/pulse_repeat_detector.sv
module pulse_repeat_detector
    import rpd_pkg::*;
#(
    parameter rpd_state_t RESET_STATE = ST_A
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  logic hit_a,
    input  logic hit_b,
    output logic match,
    output logic clash
);
    typedef struct packed {
        logic       pulse;
        rpd_state_t master;
    } regs_t;

    regs_t      r_d;
    regs_t      r_q;
    rpd_state_t slave_q;
    rpd_state_t pend;
    logic       illegal;
    logic       commit;
    logic [STATE_W-1:0] jk_j;
    logic [STATE_W-1:0] jk_k;

    rpd_next u_next (
        .cur     (slave_q),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .nxt     (pend),
        .illegal (illegal)
    );

    always_comb begin
        r_d        = r_q;
        r_d.pulse  = pulse;
        if (pulse) r_d.master = pend;
        commit     = r_q.pulse & ~pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{pulse: 1'b0, master: RESET_STATE};
        else     r_q <= r_d;
    end

    // J-K excitation: drive J for target 1, K for target 0, only on commit.
    always_comb begin
        jk_j = {STATE_W{commit}} & r_q.master;
        jk_k = {STATE_W{commit}} & ~r_q.master;
    end

    generate
        for (genvar g = 0; g < STATE_W; g++) begin : g_bit
            rpd_jk_bit #(.RST_VAL(RESET_STATE[g])) u_jk (
                .clk (clk),
                .rst (rst),
                .j   (jk_j[g]),
                .k   (jk_k[g]),
                .q   (slave_q[g])
            );
        end
    endgenerate

    always_comb begin
        if (pulse)       match = pend.lvl;
        else if (commit) match = r_q.master.lvl;
        else             match = slave_q.lvl;
        clash = pulse & illegal;
    end
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker (
    input logic clk,
    input logic rst,
    input logic pulse,
    input logic hit_a,
    input logic hit_b,
    input logic match,
    input logic clash,
    input logic s_last,
    input logic s_lvl
);
    assert_repeat_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse && hit_a && !hit_b && !s_last) |-> match);

    assert_other_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (pulse && hit_b && !hit_a && !s_last) |-> !match);

    assert_idle_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (pulse && !hit_a && !hit_b) |-> (match == s_lvl));

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !$past(pulse) && !$past(rst)) |-> $stable(match));

    assert_both_high_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse && hit_a && hit_b) |-> (clash && match == s_lvl));

    assert_no_clash_R9: assert property (@(posedge clk) disable iff (rst)
        !pulse |-> !clash);
endmodule

bind pulse_repeat_detector rpd_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .pulse  (pulse),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .match  (match),
    .clash  (clash),
    .s_last (slave_q.last_b),
    .s_lvl  (slave_q.lvl)
);

// File: tb/pulse_repeat_detector_test.sv
module pulse_repeat_detector_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse = 1'b0;
    logic hit_a = 1'b0;
    logic hit_b = 1'b0;
    logic match;
    logic clash;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // reference model: remembered line (0=a,1=b), level, pending during pulse
    int ref_last = 0;
    int ref_lvl = 0;
    int pend_last = 0;
    int pend_lvl = 0;
    bit prev_pulse = 0;

    always #2 clk = ~clk;   // 250 MHz

    pulse_repeat_detector uut (
        .clk(clk), .rst(rst), .pulse(pulse), .hit_a(hit_a), .hit_b(hit_b),
        .match(match), .clash(clash)
    );

    task automatic compare(input string req, input int exp_m, input int exp_c);
        vectors++;
        if (match !== exp_m[0] || clash !== exp_c[0]) begin
            fails++;
            $display("FAIL %s: match=%b clash=%b expected match=%0d clash=%0d",
                     req, match, clash, exp_m, exp_c);
        end
    endtask

    // drive one clock cycle of stimulus, then check against the model
    task automatic step(input bit p, input bit a, input bit b, input string req);
        int em;
        int ec;
        @(negedge clk);
        pulse = p; hit_a = a; hit_b = b;
        if (p) begin
            pend_last = ref_last; pend_lvl = ref_lvl;
            if (a && !b) begin pend_lvl = (ref_last == 0); pend_last = 0; end
            else if (b && !a) begin pend_lvl = (ref_last == 1); pend_last = 1; end
        end else if (prev_pulse) begin
            ref_last = pend_last; ref_lvl = pend_lvl;
        end
        prev_pulse = p;
        #1;
        em = p ? pend_lvl : ref_lvl;
        ec = (p && a && b) ? 1 : 0;
        compare(req, em, ec);
    endtask

    task automatic pulse_of(input bit a, input bit b, input int len, input int gap, input string req);
        for (int i = 0; i < len; i++) step(1'b1, a, b, req);
        for (int i = 0; i < gap; i++) step(1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)), "R7");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: expired, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 compare("R1", 0, 0);
        @(negedge clk); rst = 1'b0;
        #1 compare("R1", 0, 0);
        // R1: first hit_a pulse after reset repeats the reset memory
        pulse_of(1, 0, 1, 1, "R1");
        // R2: repeat on a, idle gap pulses, repeat again (R4)
        pulse_of(1, 0, 2, 2, "R2");
        pulse_of(0, 0, 3, 1, "R4");
        pulse_of(1, 0, 1, 1, "R4");
        // R3: switch to b clears, then b repeats (R2)
        pulse_of(0, 1, 2, 3, "R3");
        pulse_of(0, 1, 1, 1, "R2");
        // R8: both high holds, clash flagged
        pulse_of(1, 1, 3, 2, "R8");
        pulse_of(0, 1, 1, 1, "R8");
        pulse_of(1, 0, 1, 1, "R3");
        pulse_of(1, 1, 1, 1, "R8");
        pulse_of(1, 0, 1, 1, "R2");
        // R5/R6: back-to-back one-cycle pulses with one-cycle gaps
        pulse_of(0, 1, 1, 1, "R5");
        pulse_of(1, 0, 1, 1, "R5");
        pulse_of(1, 0, 1, 1, "R6");
        // long gap with wiggling lines
        pulse_of(0, 0, 1, 10, "R7");
        pulse_of(1, 0, 1, 1, "R4");
        // random legal sequences, with idle runs
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(3);
            bit a = (sel == 1);
            bit b = (sel == 2);
            pulse_of(a, b, 1 + $urandom_range(2), 1 + $urandom_range(2), "R6");
        end
        // R9: no clash across a quiet stretch
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R9");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule